// File: doc/BRIEF.md
# Semaphore Scratchpad Register Bank

This block holds sixteen 32-bit scratchpad words behind a plain register-access port. The port has a byte address, a write strobe with per-byte enables, write data and read data. Every word can be reached through a plain window, where reads and writes have no conditions. Words 4 to 15 can also be reached through a second, conditional window. A read through the conditional window returns the same word. A write through it lands only if bit 0 of the word is clear at the moment of the write.

Firmware uses the conditional window as a test-and-set semaphore. It writes a value with bit 0 set through the conditional address, then reads the word back. If the read returns its own value, it holds the semaphore. It releases the semaphore with a plain-window write that clears bit 0.

There are two resets. The cold reset clears everything. The warm reset clears every word except words 4 to 7, which are sticky. A global lock input blocks all writes. The port has no handshake. Read data is combinational from the address, and a write takes effect on the rising clock edge where the strobe is high.

Top module: `semsp_bank`

## Requirements
- R1: While `cold_rst_n` is low at a rising edge, all sixteen words become 0x00000000.
- R2: Plain window: word n (0 to 15) is at byte address 4·n (0x000 to 0x03C). A write there always updates the word, unless it is locked or a reset is active.
- R3: Conditional window: words 4 to 8 are at 0x0EC + 4·(n−4), and words 9 to 15 are at 0x104 + 4·(n−9). A read there returns the word's current contents.
- R4: A write through the conditional window updates the word only if the word's bit 0 is 0 before the edge. Otherwise the write is dropped and the word keeps its value.
- R5: `wr_be[k]` gates bits 8k+7:8k of a write, so a disabled byte keeps its old value. The conditional test uses the full old bit 0 whatever the byte enables are.
- R6: Address 0x100 and every address not listed in R2 or R3 read as zero. Writes to them change no word.
- R7: While `lock` is high, writes through either window change no word.
- R8: While `warm_rst_n` is low (and `cold_rst_n` is high), words 4 to 7 keep their value and all other words become zero.
- R9: While either reset is low, writes are ignored.
- R10: `rd_data` follows `addr` in the same cycle. A written value appears on `rd_data` in the cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| cold_rst_n | input | 1 | Synchronous cold reset, active low; clears all words |
| warm_rst_n | input | 1 | Synchronous warm reset, active low; spares words 4 to 7 |
| lock | input | 1 | High blocks every write |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |

## Verification
The bench targets the skipped address 0x100. A decoder that filled the gap by stepping linearly would either shift words 9 to 15 by one slot or map 0x100 onto a word, and the reads would show it. It issues a conditional write with only the upper bytes enabled onto a word whose bit 0 is set. A design that tested only the enabled bytes would let that write through. It also sets the semaphore, retries through the conditional window, releases with a plain write and retries again, and pulses warm reset over a fully written bank. A wrong sticky range or a reset that did not block writes shows up as a mismatch against the behavioural model, which is compared on every cycle.

// File: rtl/semsp_pkg.sv
package semsp_pkg;
  localparam int DW  = 32;
  localparam int AW  = 12;
  localparam int BEW = DW / 8;

  typedef logic [DW-1:0] word_t;

  localparam logic [AW-1:0] PLAIN_BASE = 12'h000;
  localparam logic [AW-1:0] COND_BASE  = 12'h0EC;
  localparam logic [AW-1:0] COND_HOLE  = 12'h100;
  localparam int            COND_FIRST = 4;

  // conditional alias address of entry idx; steps over the hole slot
  function automatic logic [AW-1:0] cond_addr(input int idx);
    logic [AW-1:0] a;
    a = COND_BASE + AW'(4 * (idx - COND_FIRST));
    if (a >= COND_HOLE) a = a + AW'(4);
    return a;
  endfunction
endpackage

// File: rtl/semsp_decode.sv
module semsp_decode
  import semsp_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] plain_hit,
  output logic [NREG-1:0] cond_hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [AW-1:0] P_ADDR = PLAIN_BASE + AW'(4 * i);
    assign plain_hit[i] = (addr == P_ADDR);
    if (i >= COND_FIRST) begin : g_cond
      localparam logic [AW-1:0] C_ADDR = cond_addr(i);
      assign cond_hit[i] = (addr == C_ADDR);
    end else begin : g_nocond
      assign cond_hit[i] = 1'b0;
    end
  end
endmodule

// File: rtl/semsp_entry.sv
module semsp_entry
  import semsp_pkg::*;
#(
  parameter bit STICKY = 1'b0
) (
  input  logic           clk,
  input  logic           cold_rst_n,
  input  logic           warm_rst_n,
  input  logic           lock,
  input  logic           wr_en,
  input  logic [BEW-1:0] wr_be,
  input  word_t          wr_data,
  input  logic           plain_hit,
  input  logic           cond_hit,
  output word_t          q
);
  logic  in_reset, sem_open, accept;
  word_t merged;

  assign in_reset = !cold_rst_n || !warm_rst_n;
  assign sem_open = !q[0];
  assign accept   = wr_en && !lock && !in_reset &&
                    (plain_hit || (cond_hit && sem_open));

  always_comb begin
    for (int b = 0; b < BEW; b++)
      merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : q[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n)                q <= '0;
    else if (!warm_rst_n && !STICKY) q <= '0;
    else if (accept)                 q <= merged;
  end

  // R1
  cold_clear_chk: assert property (@(posedge clk)
    !cold_rst_n |=> (q == '0));

  // R4
  sem_reject_chk: assert property (@(posedge clk) disable iff (in_reset)
    (wr_en && cond_hit && !plain_hit && q[0]) |=> $stable(q));

  // R5
  byte_keep_chk: assert property (@(posedge clk) disable iff (in_reset)
    (wr_en && !lock && plain_hit && !wr_be[0]) |=> $stable(q[7:0]));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (in_reset)
    lock |=> $stable(q));

  if (STICKY) begin : g_sticky_chk
    // R8
    warm_keep_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !warm_rst_n |=> $stable(q));
  end else begin : g_plain_chk
    // R8
    warm_clear_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !warm_rst_n |=> (q == '0));
  end
endmodule

// File: rtl/semsp_rdmux.sv
module semsp_rdmux
  import semsp_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [NREG-1:0]         sel,
  output word_t                   rd
);
  always_comb begin
    rd = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rd = rd | regs[i];
  end
endmodule

// File: rtl/semsp_bank.sv
module semsp_bank
  import semsp_pkg::*;
#(
  parameter int NREG         = 16,
  parameter int STICKY_FIRST = 4,
  parameter int STICKY_LAST  = 7
) (
  input  logic          clk,
  input  logic          cold_rst_n,
  input  logic          warm_rst_n,
  input  logic          lock,
  input  logic [11:0]   addr,
  input  logic          wr_en,
  input  logic [3:0]    wr_be,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data
);
  logic [NREG-1:0]         plain_hit, cond_hit, sel;
  logic [NREG-1:0][DW-1:0] regs;

  semsp_decode #(.NREG(NREG)) u_dec (
    .addr(addr), .plain_hit(plain_hit), .cond_hit(cond_hit)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    localparam bit IS_STICKY = (i >= STICKY_FIRST) && (i <= STICKY_LAST);
    semsp_entry #(.STICKY(IS_STICKY)) u_ent (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .lock(lock), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
      .plain_hit(plain_hit[i]), .cond_hit(cond_hit[i]), .q(regs[i])
    );
  end

  assign sel = plain_hit | cond_hit;

  semsp_rdmux #(.NREG(NREG)) u_rd (
    .regs(regs), .sel(sel), .rd(rd_data)
  );

  // R3
  single_hit_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $countones({plain_hit, cond_hit}) <= 1);

  // R6
  hole_read_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (addr == COND_HOLE) |-> (rd_data == '0));

  // R6
  hole_write_chk: assert property (@(posedge clk)
    disable iff (!cold_rst_n || !warm_rst_n)
    (wr_en && addr == COND_HOLE) |=> $stable(regs));
endmodule

// File: tb/tb_semsp_bank.sv
module tb_semsp_bank;
  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0, warm_rst_n = 1'b1, lock = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  logic [31:0] m [16];

  always #5 clk = ~clk;

  semsp_bank dut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .lock(lock),
    .addr(addr), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  function automatic int plain_idx(input logic [11:0] a);
    if (a < 12'h040 && a[1:0] == 2'b00) return int'(a) / 4;
    return -1;
  endfunction

  function automatic int cond_idx(input logic [11:0] a);
    case (a)
      12'h0EC: return 4;   12'h0F0: return 5;   12'h0F4: return 6;
      12'h0F8: return 7;   12'h0FC: return 8;   12'h104: return 9;
      12'h108: return 10;  12'h10C: return 11;  12'h110: return 12;
      12'h114: return 13;  12'h118: return 14;  12'h11C: return 15;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, d, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  // one bus cycle: drive, compare read (R10 same-cycle), update model, clock
  task automatic op(input logic c, w, lk, we, input logic [11:0] a,
                    input logic [3:0] be, input logic [31:0] d, input string tag);
    int pi, ci, ix;
    logic [31:0] exp;
    @(negedge clk);
    cold_rst_n = c; warm_rst_n = w; lock = lk; wr_en = we;
    addr = a; wr_be = be; wr_data = d;
    #1;
    pi = plain_idx(a); ci = cond_idx(a);
    ix = (pi >= 0) ? pi : ci;
    exp = (ix >= 0) ? m[ix] : 32'h0;
    if (tag != "") begin
      checks++;
      if (rd_data !== exp) begin
        fails++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
      end
    end
    if (!c) begin
      for (int i = 0; i < 16; i++) m[i] = '0;
    end else if (!w) begin
      for (int i = 0; i < 16; i++) if (i < 4 || i > 7) m[i] = '0;
    end else if (we && !lk) begin
      if (pi >= 0) m[pi] = merge(m[pi], d, be);
      else if (ci >= 0 && m[ci][0] == 1'b0) m[ci] = merge(m[ci], d, be);
    end
    @(posedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    op(1, 1, 0, 0, a, 4'h0, 32'h0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] be,
                    input logic [31:0] d, input string tag);
    op(1, 1, 0, 1, a, be, d, tag);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 'x;
    op(0, 1, 0, 0, 12'h0, 4'h0, 32'h0, "");
    op(0, 1, 0, 1, 12'h0, 4'hF, 32'hFFFF_FFFF, "");
    // R1 reset state
    for (int i = 0; i < 16; i++) rd(12'(4 * i), "R1");
    // R2 plain write, R3 conditional alias read of word 5
    wr(12'h014, 4'hF, 32'h0000_0001, "R2");
    rd(12'h014, "R2");
    rd(12'h0F0, "R3");
    // R4 semaphore held: conditional write dropped
    wr(12'h0F0, 4'hF, 32'hAAAA_AAA0, "R4");
    rd(12'h014, "R4");
    // release, then acquire, then retry
    wr(12'h014, 4'hF, 32'h0, "R2");
    wr(12'h0F0, 4'hF, 32'h1234_5671, "R4");
    rd(12'h0F0, "R4");
    wr(12'h0F0, 4'hF, 32'h0000_0055, "R4");
    rd(12'h014, "R4");
    // R3 word 8 sits before the hole, word 9 after it
    wr(12'h0FC, 4'hF, 32'h0000_0800, "R3");
    rd(12'h020, "R3");
    // R5 byte enables and full bit-0 test
    wr(12'h104, 4'b0010, 32'hFFFF_FF00, "R5");
    rd(12'h024, "R5");
    wr(12'h024, 4'b0001, 32'h0000_0001, "R5");
    wr(12'h104, 4'b1100, 32'hFFFF_0000, "R5");
    rd(12'h104, "R5");
    // R6 hole and unmapped
    wr(12'h100, 4'hF, 32'hFFFF_FFFF, "R6");
    rd(12'h100, "R6");
    rd(12'h020, "R6");
    rd(12'h024, "R6");
    wr(12'h200, 4'hF, 32'hDEAD_BEEF, "R6");
    rd(12'h200, "R6");
    rd(12'h002, "R6");
    // R7 lock on both windows
    op(1, 1, 1, 1, 12'h000, 4'hF, 32'h5, "R7");
    op(1, 1, 1, 1, 12'h110, 4'hF, 32'h6, "R7");
    rd(12'h000, "R7");
    rd(12'h030, "R7");
    // R8 warm reset over a full bank, R9 write during reset ignored
    for (int i = 0; i < 16; i++) wr(12'(4 * i), 4'hF, 32'h0100_0000 + 32'(i * 2), "R2");
    op(1, 0, 0, 1, 12'h010, 4'hF, 32'hFFFF_FFFF, "R9");
    op(1, 0, 0, 1, 12'h018, 4'hF, 32'hFFFF_FFFF, "R9");
    for (int i = 0; i < 16; i++) rd(12'(4 * i), "R8");
    // R1 cold reset clears sticky words too
    op(0, 1, 0, 1, 12'h010, 4'hF, 32'h1, "");
    for (int i = 4; i < 8; i++) rd(12'(4 * i), "R1");
    // R10 random traffic, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      int r = $urandom_range(0, 99);
      case ($urandom_range(0, 3))
        0: a = 12'(4 * $urandom_range(0, 15));
        1: a = 12'h0EC + 12'(4 * $urandom_range(0, 12));
        2: a = 12'h100;
        default: a = 12'($urandom_range(0, 12'h13F));
      endcase
      op((r != 0), (r > 2), ($urandom_range(0, 9) == 0), $urandom_range(0, 1) == 1,
         a, 4'($urandom_range(0, 15)), $urandom, "R10");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule